// File: doc/BRIEF.md
# Soft-Ramped Quarter-dB Volume Control

This block scales a group of signed audio channels by a per-channel volume and a shared master volume. Both volumes are 10-bit indices on a quarter-decibel scale: each increment of the index lowers the gain by 0.25 dB. Index 0x048 is unity gain and index 0x001 is the loudest setting, at +17.75 dB. The softest audible index is 0x243, at -126.75 dB. Index 0x000, and any index above 0x243, means mute.

New volume settings never take effect in one jump. A write only sets a target. The current index of each volume then walks toward its target one quarter-dB step at a time. One step is taken every N input samples, where N is a programmable update interval of up to 255 samples. A typical setting is 63. While any volume is still walking, the block raises `busy` and drops further writes, so that a ramp is never disturbed halfway.

After reset the master volume is muted and every channel volume sits at unity. The outputs are therefore silent until a non-mute master volume is written and has ramped in. The linear gain comes from a 24-entry mantissa table, one entry per quarter-dB within a 6 dB octave, followed by one right shift for every 6 dB of attenuation. Results that exceed the sample range are clipped.

Top module: `soft_vol`

## Requirements
- R1: After reset, `busy` is low, the master volume is mute so every output sample is 0, and every channel volume is index 0x048.
- R2: A written index of 0x000, or any index above 0x243, is stored as the mute setting. Writing a mute code to a volume that is already muted starts no ramp.
- R3: The effective index of a channel is its current channel index plus the current master index minus 0x048. A result below 0x001 is clamped to 0x001. A result above 0x243, or a mute channel or master volume, gives zero gain.
- R4: For effective index k, let e = k + 24, s = e / 24 and f = e mod 24. The mantissa m is round(32768 * 2^(-f/24)). The gain is g = floor(m * 8 / 2^(s-1)). The output is floor(x * g / 32768), so with both volumes at 0x048 the output equals the input.
- R5: An output that exceeds the W-bit signed range is clipped to the largest positive or the most negative value.
- R6: A write to an idle block sets the target of the selected volume (`wr_master` = 1 picks the master, otherwise channel `wr_ch`). Each current index then moves one step toward its target on every update tick, and `busy` is high from the cycle after the write until all current indices equal their targets.
- R7: An update tick occurs on the N-th accepted sample after the last tick or accepted write, where N is `upd_interval`, and 0 is treated as 1. An accepted write restarts this count, and a sample in the same cycle as an accepted write does not tick.
- R8: A write while `busy` is high is dropped and changes no target.
- R9: `out_valid` follows `sample_valid` by one cycle. Each output uses the current indices from before the tick taken on that same clock edge.
- R10: When no ramp is pending and no write occurs, the current indices stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Volume write strobe |
| wr_master | input | 1 | 1 selects the master volume, 0 selects channel `wr_ch` |
| wr_ch | input | CHW | Channel selected by a write |
| wr_index | input | 10 | Quarter-dB volume index to write |
| upd_interval | input | 8 | Samples per ramp step (0 acts as 1) |
| sample_valid | input | 1 | Input samples present |
| sample_in | input | NCH*W | Signed samples, channel k at bits [k*W +: W] |
| sample_out | output | NCH*W | Scaled, clipped samples, same packing |
| out_valid | output | 1 | Output samples present |
| busy | output | 1 | A volume ramp is in progress |

## Verification
Two functions can land on the same clock edge. An accepted volume write can arrive together with an input sample, and a ramp tick can coincide with the sample whose gain it would alter. The bench provokes both with random writes, random sample gaps and random update intervals of 0 to 3, and at times pairs a write with a sample in a single cycle. A reference model of targets, current indices and the tick count predicts every output word. From that model the bench checks that the coincident sample used the old gain and that the tick count restarted. Writes issued during a ramp are checked in the same way: the model drops them, and the outputs after the ramp settles show whether the design did too.

// File: rtl/soft_vol.sv
module soft_vol #(
  parameter int NCH = 4,
  parameter int W   = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_master,
  input  logic [(NCH>1 ? $clog2(NCH) : 1)-1:0] wr_ch,
  input  logic [9:0]       wr_index,
  input  logic [7:0]       upd_interval,
  input  logic             sample_valid,
  input  logic [NCH*W-1:0] sample_in,
  output logic [NCH*W-1:0] sample_out,
  output logic             out_valid,
  output logic             busy
);

  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1;
  localparam logic [9:0] UNITY = 10'h048;
  localparam logic [9:0] LAST  = 10'h243;
  localparam logic [9:0] MUTE  = 10'h244;
  localparam int MF = 15;
  localparam int GW = 19;
  localparam int PW = W + GW + 1;

  function automatic logic [24*16-1:0] build_mant();
    logic [24*16-1:0] t;
    t = '0;
    for (int j = 0; j < 24; j++) begin
      real r;
      r = (2.0 ** (-real'(j) / 24.0)) * 32768.0;
      t[j*16 +: 16] = 16'($rtoi(r + 0.5));
    end
    return t;
  endfunction

  localparam logic [24*16-1:0] MANT = build_mant();

  function automatic logic [9:0] norm(input logic [9:0] v);
    return (v == 10'd0 || v > LAST) ? MUTE : v;
  endfunction

  function automatic logic [9:0] toward(input logic [9:0] cur, input logic [9:0] tgt);
    if (cur < tgt) return cur + 10'd1;
    else if (cur > tgt) return cur - 10'd1;
    else return cur;
  endfunction

  logic [9:0] m_cur, m_tgt;
  logic [9:0] c_cur [NCH];
  logic [9:0] c_tgt [NCH];
  logic [NCH-1:0] c_move;
  logic [7:0] cnt;
  logic accept, tick;
  logic [8:0] n_eff;

  assign busy   = (m_cur != m_tgt) || (|c_move);
  assign accept = wr_en && !busy;
  assign n_eff  = (upd_interval == 8'd0) ? 9'd1 : {1'b0, upd_interval};
  assign tick   = sample_valid && !accept && ({1'b0, cnt} + 9'd1 >= n_eff);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      m_cur <= MUTE;
      m_tgt <= MUTE;
    end else begin
      if (accept) cnt <= '0;
      else if (tick) cnt <= '0;
      else if (sample_valid) cnt <= cnt + 8'd1;
      if (accept && wr_master) m_tgt <= norm(wr_index);
      if (tick) m_cur <= toward(m_cur, m_tgt);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_valid <= 1'b0;
    else out_valid <= sample_valid;
  end

  for (genvar k = 0; k < NCH; k++) begin : g_ch
    logic [10:0] sum, eff;
    logic        mute;
    logic [9:0]  e;
    logic [4:0]  shf, fr;
    logic [15:0] mant;
    logic [GW-1:0] gain;
    logic signed [PW-1:0] prod, hi;
    logic ovf;
    logic [W-1:0] res, out_r;

    assign c_move[k] = (c_cur[k] != c_tgt[k]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        c_cur[k] <= UNITY;
        c_tgt[k] <= UNITY;
      end else begin
        if (accept && !wr_master && wr_ch == CHW'(k)) c_tgt[k] <= norm(wr_index);
        if (tick) c_cur[k] <= toward(c_cur[k], c_tgt[k]);
      end
    end

    assign sum  = {1'b0, c_cur[k]} + {1'b0, m_cur};
    assign eff  = (sum < 11'd73) ? 11'd1 : sum - 11'd72;
    assign mute = (c_cur[k] == MUTE) || (m_cur == MUTE) || (eff > {1'b0, LAST});
    assign e    = mute ? 10'd24 : 10'(eff) + 10'd24;
    assign shf  = 5'(e / 10'd24);
    assign fr   = 5'(e % 10'd24);
    assign mant = MANT[int'(fr)*16 +: 16];
    assign gain = mute ? '0 : ({mant, 3'b000} >> (shf - 5'd1));
    assign prod = PW'($signed(sample_in[k*W +: W])) * $signed({1'b0, gain});
    assign hi   = prod >>> MF;
    assign ovf  = !((&hi[PW-1:W-1]) || !(|hi[PW-1:W-1]));
    assign res  = ovf ? (hi[PW-1] ? {1'b1, {(W-1){1'b0}}} : {1'b0, {(W-1){1'b1}}})
                      : hi[W-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) out_r <= '0;
      else if (sample_valid) out_r <= res;
    end
    assign sample_out[k*W +: W] = out_r;

    // R6: a channel index moves by at most one step per cycle
    a_r6_chan_step: assert property (@(posedge clk) disable iff (!rst_n)
      (c_cur[k] == $past(c_cur[k])) || (c_cur[k] == $past(c_cur[k]) + 10'd1) ||
      (c_cur[k] == $past(c_cur[k]) - 10'd1));

    // R8: a write during a ramp leaves the channel target untouched
    a_r8_chan_drop: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && busy) |=> $stable(c_tgt[k]));

    // R10: idle and no write keeps the channel index where it is
    a_r10_chan_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !wr_en) |=> $stable(c_cur[k]));
  end

  // R6: the master index moves by at most one step per cycle
  a_r6_master_step: assert property (@(posedge clk) disable iff (!rst_n)
    (m_cur == $past(m_cur)) || (m_cur == $past(m_cur) + 10'd1) ||
    (m_cur == $past(m_cur) - 10'd1));

  // R8: a write during a ramp leaves the master target untouched
  a_r8_master_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && busy) |=> $stable(m_tgt));

  // R1, R3: a muted master silences every channel of the next output
  a_r3_master_mute: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_valid && m_cur == MUTE) |=> (sample_out == '0));

  // R7: without an accepted sample the indices cannot step
  a_r7_no_tick_without_sample: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_valid |=> $stable(m_cur));

endmodule

// File: tb/soft_vol_tb_top.sv
`timescale 1ns/1ps
module soft_vol_tb_top;
  localparam int NCH = 4;
  localparam int W   = 24;
  localparam int MUTE = 'h244;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, wr_master = 1'b0;
  logic [1:0] wr_ch = '0;
  logic [9:0] wr_index = '0;
  logic [7:0] upd_interval = '0;
  logic sample_valid = 1'b0;
  logic [NCH*W-1:0] sample_in = '0;
  logic [NCH*W-1:0] sample_out;
  logic out_valid, busy;

  always #2.5 clk = ~clk;

  soft_vol #(.NCH(NCH), .W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_master(wr_master), .wr_ch(wr_ch),
    .wr_index(wr_index), .upd_interval(upd_interval), .sample_valid(sample_valid),
    .sample_in(sample_in), .sample_out(sample_out), .out_valid(out_valid), .busy(busy));

  int checks = 0, errors = 0;
  bit done = 0;
  int m_cur, m_tgt, cnt;
  int c_cur [NCH];
  int c_tgt [NCH];
  int seed_dummy;

  function automatic int normi(int v);
    return (v == 0 || v > 'h243) ? MUTE : v;
  endfunction

  function automatic bit model_busy();
    bit b = (m_cur != m_tgt);
    for (int k = 0; k < NCH; k++) if (c_cur[k] != c_tgt[k]) b = 1;
    return b;
  endfunction

  function automatic int toward(int c, int t);
    return (c < t) ? c + 1 : (c > t) ? c - 1 : c;
  endfunction

  function automatic longint expect_out(longint x, int c, int m);
    int sum, eff, e, s, f;
    longint mant, g, q;
    longint smax = (longint'(1) << (W-1)) - 1;
    if (c == MUTE || m == MUTE) return 0;
    sum = c + m;
    eff = (sum < 73) ? 1 : sum - 72;
    if (eff > 'h243) return 0;
    e = eff + 24; s = e / 24; f = e % 24;
    mant = $rtoi((2.0 ** (-real'(f) / 24.0)) * 32768.0 + 0.5);
    g = (mant * 8) >> (s - 1);
    q = (x * g) >>> 15;
    if (q > smax) q = smax;
    if (q < -smax - 1) q = -smax - 1;
    return q;
  endfunction

  function automatic int rnd_sample();
    int r = $urandom_range(0, 9);
    if (r == 0) return (1 << (W-1)) - 1;
    if (r == 1) return -(1 << (W-1));
    return int'($urandom) >>> (32 - W);
  endfunction

  task automatic check(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(bit wr, bit wm, int wc, int wi, bit sv, string tag);
    longint xin [NCH];
    longint exp_o [NCH];
    bit acc, tk;
    int n;
    @(negedge clk);
    wr_en = wr; wr_master = wm; wr_ch = 2'(wc); wr_index = 10'(wi);
    sample_valid = sv;
    for (int k = 0; k < NCH; k++) begin
      xin[k] = rnd_sample();
      sample_in[k*W +: W] = W'(xin[k]);
      exp_o[k] = expect_out(xin[k], c_cur[k], m_cur);
    end
    acc = wr && !model_busy();
    n = (upd_interval == 0) ? 1 : int'(upd_interval);
    tk = 0;
    if (acc) begin
      cnt = 0;
      if (wm) m_tgt = normi(wi); else c_tgt[wc] = normi(wi);
    end else if (sv) begin
      if (cnt + 1 >= n) begin tk = 1; cnt = 0; end else cnt++;
    end
    if (tk) begin
      m_cur = toward(m_cur, m_tgt);
      for (int k = 0; k < NCH; k++) c_cur[k] = toward(c_cur[k], c_tgt[k]);
    end
    @(posedge clk); #1;
    wr_en = 0; sample_valid = 0;
    check(out_valid == sv, {tag, " R9 out_valid"}, out_valid, sv);
    if (sv)
      for (int k = 0; k < NCH; k++) begin
        longint a = $signed(sample_out[k*W +: W]);
        check(a == exp_o[k], $sformatf("%s ch%0d", tag, k), a, exp_o[k]);
      end
    check(busy == model_busy(), {tag, " R6 busy"}, busy, model_busy());
  endtask

  task automatic settle(string tag);
    while (model_busy()) cyc(0, 0, 0, 0, 1, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R6 watchdog actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    seed_dummy = $urandom(32'd1234);
    m_cur = MUTE; m_tgt = MUTE; cnt = 0;
    for (int k = 0; k < NCH; k++) begin c_cur[k] = 'h048; c_tgt[k] = 'h048; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    #1 check(busy == 0, "R1 busy after reset", busy, 0);
    cyc(0, 0, 0, 0, 1, "R1 muted output");

    // master ramps in from mute, one step per sample
    upd_interval = 0;
    cyc(1, 1, 0, 'h048, 0, "R6 master write");
    settle("R6 ramp in");
    for (int i = 0; i < 8; i++) cyc(0, 0, 0, 0, 1, "R4 unity");

    // interval of 63 samples per step
    upd_interval = 63;
    cyc(1, 0, 1, 'h049, 0, "R7 write");
    n = 0;
    while (busy && n < 1000) begin cyc(0, 0, 0, 0, 1, "R7 wait"); n++; end
    check(n == 63, "R7 samples per step", n, 63);

    // dropped write during a ramp
    upd_interval = 0;
    cyc(1, 0, 1, 'h050, 0, "R8 first");
    cyc(1, 0, 1, 'h060, 1, "R8 dropped");
    settle("R8 ramp");
    cyc(0, 0, 0, 0, 1, "R8 settled");

    // saturation and low-side clamp
    cyc(1, 0, 0, 'h001, 0, "R5 write");
    settle("R5 ramp");
    for (int i = 0; i < 10; i++) cyc(0, 0, 0, 0, 1, "R5 clip");
    cyc(1, 1, 0, 'h001, 1, "R3 master loud");
    settle("R3 ramp");
    for (int i = 0; i < 6; i++) cyc(0, 0, 0, 0, 1, "R3 clamp");
    cyc(1, 1, 0, 'h048, 0, "R3 restore");
    settle("R3 restore ramp");

    // mute codes
    cyc(1, 0, 3, 'h3FF, 0, "R2 high code");
    settle("R2 ramp");
    cyc(0, 0, 0, 0, 1, "R2 muted ch3");
    cyc(1, 0, 3, 'h000, 0, "R2 zero code");
    check(busy == 0, "R2 no ramp for equal mute", busy, 0);
    cyc(1, 0, 3, 'h048, 0, "R2 restore");
    settle("R2 restore ramp");

    // constrained random mix
    for (int it = 0; it < 24; it++) begin
      int r, idx, ch;
      bit wm;
      upd_interval = 8'($urandom_range(0, 3));
      r = $urandom_range(0, 9);
      idx = (r == 0) ? 0 : (r == 1) ? 'h3FF : $urandom_range('h030, 'h070);
      wm = ($urandom_range(0, 4) == 0);
      if (wm && (idx == 0 || idx == 'h3FF)) idx = 'h050;
      ch = $urandom_range(0, NCH-1);
      cyc(1, wm, ch, idx, $urandom_range(0, 1), "R7 random write");
      while (model_busy()) begin
        bit w = ($urandom_range(0, 19) == 0);
        cyc(w, 0, $urandom_range(0, NCH-1), $urandom_range(1, 'h243),
            $urandom_range(0, 3) != 0, "R8 random ramp");
      end
      for (int i = 0; i < 3; i++) cyc(0, 0, 0, 0, 1, "R10 random idle");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule